// File: doc/BRIEF.md
# Auto-Sequenced Fuse Word Reader

This block reads one 32-bit word from a one-time-programmable fuse array without software driving the array pins. Software writes a control register that holds a word address and two command bits. When both bits are set in a single write and the block is idle, an internal sequencer moves through a setup phase, a strobe phase, a capture phase and a completion phase. Each phase lasts a fixed number of clock cycles set by a parameter. During these phases the sequencer drives the array's select, load and strobe pins.

The captured word appears in a read-only data register and stays there until the next read completes. At completion, a flag in a status register is set. The interrupt output follows that flag. Software clears the flag by writing a one to it. Software reads consecutive words by raising the address by one for each access.

A parameterised array model inside the block supplies the word contents. Each word is computed from its address, and addresses beyond the array depth read as zero.

Top module: `fuse_auto_reader`

## Requirements
- R1: After reset, the status, data and control registers all read 0, and `irq`, `fuseCs`, `fuseLoad` and `fuseStrobe` are all low.
- R2: A read starts only when one write to control (offset 0x24) sets both bit 0 (enable) and bit 1 (read command) while idle. A write that sets only one of these bits leaves busy (control bit 31) low and never sets the completion flag.
- R3: The busy bit (control bit 31) is high from the clock edge that accepts a start. The completion flag (status offset 0x18, bit 0) rises, and busy falls, exactly SETUP_CYC+STROBE_CYC+CAPTURE_CYC+DONE_CYC edges after the start edge. With the defaults that is 15 edges, under 4 µs at any bus clock above 4 MHz.
- R4: Data-out (offset 0x20) returns the word at the address in control bits 25:16. The word at address a is `{6'b0, a, 6'b0, a} ^ SEED`, with a default SEED of 32'h5A5AA5A5.
- R5: An address at or above DEPTH (default 768) returns 32'h0.
- R6: Writing 1 to status bit 0 clears the flag. Writing 0 to that bit has no effect, and other bits of the write are ignored. `irq` equals the flag.
- R7: A control write while busy is ignored. The address, the result and the completion time of the running read are unchanged.
- R8: When the sequencer returns to idle, control bits 0 and 1 read as 0 and the address field keeps the value that was written.
- R9: Data-out changes only when a read captures. It holds through flag clears, through writes to its own offset and through the early phases of a later read.
- R10: `fuseCs` and `fuseLoad` are high during the setup, strobe and capture phases. `fuseStrobe` is high only during the strobe and capture phases, and its first cycle follows SETUP_CYC cycles of setup. All three are low when idle.
- R11: If a clear write lands on the same edge at which a read completes, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, sampled on the rising edge |
| regAddr | input | ADDR_W | Byte offset of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Completion interrupt, equal to the status flag |
| fuseCs | output | 1 | Array select pin |
| fuseLoad | output | 1 | Array load pin |
| fuseStrobe | output | 1 | Array read strobe pin |

## Verification
The hardest case to reach from the ports is a flag-clear write on the exact edge where a read completes. The set must win that race, and a one-cycle timing slip hides the case. The stimulus counts edges from the accepted start write and issues the clear write so that it is sampled on edge 15. The bench then checks that the flag stayed set.

The same edge counting places a second start write in the middle of a running read. This shows that the address, the captured word and the completion edge are all unchanged. It also samples the strobe pin exactly on both sides of the setup-to-strobe boundary.

// File: rtl/fuse_reader_pkg.sv
package fuse_reader_pkg;

  localparam int WORD_W   = 32;
  localparam int FUSE_AW  = 10;

  localparam logic [7:0] OFS_STATUS = 8'h18;
  localparam logic [7:0] OFS_DOUT   = 8'h20;
  localparam logic [7:0] OFS_CTRL   = 8'h24;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RD_BIT   = 1;
  localparam int CTRL_ADDR_LSB = 16;
  localparam int CTRL_BUSY_BIT = 31;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_SETUP,
    SEQ_STROBE,
    SEQ_CAPTURE,
    SEQ_DONE
  } seqState_t;

  typedef struct packed {
    logic busy;
    logic pinCs;
    logic pinLoad;
    logic pinStrobe;
    logic latchData;
    logic finish;
  } seqStrobes_t;

endpackage

// File: rtl/fuse_array_model.sv
module fuse_array_model
  import fuse_reader_pkg::*;
#(
  parameter int          DEPTH = 768,
  parameter logic [31:0] SEED  = 32'h5A5A_A5A5
) (
  input  logic               cs,
  input  logic               load,
  input  logic               strobe,
  input  logic [FUSE_AW-1:0] addr,
  output logic [WORD_W-1:0]  word
);

  logic inRange;
  logic [WORD_W-1:0] pattern;

  assign inRange = ({{(32-FUSE_AW){1'b0}}, addr} < 32'(DEPTH));
  assign pattern = {6'b0, addr, 6'b0, addr} ^ SEED;

  always_comb begin
    if (cs && load && strobe && inRange) word = pattern;
    else                                 word = '0;
  end

endmodule

// File: rtl/fuse_seq_ctrl.sv
module fuse_seq_ctrl
  import fuse_reader_pkg::*;
#(
  parameter int SETUP_CYC   = 4,
  parameter int STROBE_CYC  = 8,
  parameter int CAPTURE_CYC = 2,
  parameter int DONE_CYC    = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output seqStrobes_t strobes
);

  localparam int MAX_AB  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_CD  = (CAPTURE_CYC > DONE_CYC) ? CAPTURE_CYC : DONE_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int TOTAL   = SETUP_CYC + STROBE_CYC + CAPTURE_CYC + DONE_CYC;
  localparam int BCNT_W  = $clog2(TOTAL + 2);

  seqState_t state, stateNext;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseLen;
  logic lastCycle;

  always_comb begin
    unique case (state)
      SEQ_SETUP:   phaseLen = CNT_W'(SETUP_CYC);
      SEQ_STROBE:  phaseLen = CNT_W'(STROBE_CYC);
      SEQ_CAPTURE: phaseLen = CNT_W'(CAPTURE_CYC);
      SEQ_DONE:    phaseLen = CNT_W'(DONE_CYC);
      default:     phaseLen = CNT_W'(1);
    endcase
  end

  assign lastCycle = (phaseCnt == phaseLen - CNT_W'(1));

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE:    if (startReq)  stateNext = SEQ_SETUP;
      SEQ_SETUP:   if (lastCycle) stateNext = SEQ_STROBE;
      SEQ_STROBE:  if (lastCycle) stateNext = SEQ_CAPTURE;
      SEQ_CAPTURE: if (lastCycle) stateNext = SEQ_DONE;
      SEQ_DONE:    if (lastCycle) stateNext = SEQ_IDLE;
      default:                    stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      phaseCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == SEQ_IDLE || lastCycle) phaseCnt <= '0;
      else                                phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.busy      = (state != SEQ_IDLE);
    strobes.pinCs     = (state == SEQ_SETUP) || (state == SEQ_STROBE) || (state == SEQ_CAPTURE);
    strobes.pinLoad   = strobes.pinCs;
    strobes.pinStrobe = (state == SEQ_STROBE) || (state == SEQ_CAPTURE);
    strobes.latchData = (state == SEQ_CAPTURE) && lastCycle;
    strobes.finish    = (state == SEQ_DONE) && lastCycle;
  end

  // Watch counter for the bounded busy window.
  logic [BCNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busyCnt <= '0;
    else if (!strobes.busy)  busyCnt <= '0;
    else                     busyCnt <= busyCnt + BCNT_W'(1);
  end

  // R3
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BCNT_W'(TOTAL));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_CAPTURE) |=> (state == SEQ_CAPTURE) || (state == SEQ_DONE));

  // R10
  strobe_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.pinStrobe) |-> $past(state) == SEQ_SETUP);

endmodule

// File: rtl/fuse_datapath.sv
module fuse_datapath
  import fuse_reader_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter int          DEPTH  = 768,
  parameter logic [31:0] SEED   = 32'h5A5A_A5A5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  seqStrobes_t       strobes,
  output logic              startReq,
  output logic              doneFlag
);

  logic wrCtrl, wrStatus;
  logic enReg, rdReg;
  logic [FUSE_AW-1:0] addrReg;
  logic [WORD_W-1:0]  doutReg;
  logic [WORD_W-1:0]  fuseWord;
  logic unusedWdata;

  assign wrCtrl   = regWrEn && (regAddr == ADDR_W'(OFS_CTRL));
  assign wrStatus = regWrEn && (regAddr == ADDR_W'(OFS_STATUS));
  assign startReq = wrCtrl && !strobes.busy
                    && regWdata[CTRL_EN_BIT] && regWdata[CTRL_RD_BIT];
  assign unusedWdata = ^{regWdata[31:CTRL_ADDR_LSB+FUSE_AW], regWdata[CTRL_ADDR_LSB-1:2]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      rdReg   <= 1'b0;
      addrReg <= '0;
    end else if (strobes.finish) begin
      enReg <= 1'b0;
      rdReg <= 1'b0;
    end else if (wrCtrl && !strobes.busy) begin
      enReg   <= regWdata[CTRL_EN_BIT];
      rdReg   <= regWdata[CTRL_RD_BIT];
      addrReg <= regWdata[CTRL_ADDR_LSB +: FUSE_AW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               doneFlag <= 1'b0;
    else if (strobes.finish)                 doneFlag <= 1'b1;
    else if (wrStatus && regWdata[0])        doneFlag <= 1'b0;
  end

  fuse_array_model #(
    .DEPTH (DEPTH),
    .SEED  (SEED)
  ) u_array (
    .cs     (strobes.pinCs),
    .load   (strobes.pinLoad),
    .strobe (strobes.pinStrobe),
    .addr   (addrReg),
    .word   (fuseWord)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  doutReg <= '0;
    else if (strobes.latchData) doutReg <= fuseWord;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(OFS_STATUS)) regRdata = {31'b0, doneFlag};
    else if (regAddr == ADDR_W'(OFS_DOUT)) regRdata = doutReg;
    else if (regAddr == ADDR_W'(OFS_CTRL))
      regRdata = {strobes.busy, 5'b0, addrReg, 14'b0, rdReg, enReg};
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> doneFlag);

  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchData |=> $stable(doutReg));

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && strobes.busy) |=> $stable(addrReg));

  // R8
  cmd_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !enReg && !rdReg);

endmodule

// File: rtl/fuse_auto_reader.sv
module fuse_auto_reader
  import fuse_reader_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          DEPTH       = 768,
  parameter logic [31:0] SEED        = 32'h5A5A_A5A5,
  parameter int          SETUP_CYC   = 4,
  parameter int          STROBE_CYC  = 8,
  parameter int          CAPTURE_CYC = 2,
  parameter int          DONE_CYC    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq,
  output logic              fuseCs,
  output logic              fuseLoad,
  output logic              fuseStrobe
);

  seqStrobes_t strobes;
  logic startReq;
  logic doneFlag;

  fuse_seq_ctrl #(
    .SETUP_CYC   (SETUP_CYC),
    .STROBE_CYC  (STROBE_CYC),
    .CAPTURE_CYC (CAPTURE_CYC),
    .DONE_CYC    (DONE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobes  (strobes)
  );

  fuse_datapath #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .SEED   (SEED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .strobes  (strobes),
    .startReq (startReq),
    .doneFlag (doneFlag)
  );

  assign irq        = doneFlag;
  assign fuseCs     = strobes.pinCs;
  assign fuseLoad   = strobes.pinLoad;
  assign fuseStrobe = strobes.pinStrobe;

endmodule

// File: tb/fuse_auto_reader_tb.sv
module fuse_auto_reader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 15;
  localparam int DEPTH      = 768;
  localparam logic [31:0] SEED = 32'h5A5A_A5A5;
  localparam logic [7:0] A_STATUS = 8'h18;
  localparam logic [7:0] A_DOUT   = 8'h20;
  localparam logic [7:0] A_CTRL   = 8'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic irq, fuseCs, fuseLoad, fuseStrobe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_auto_reader #(
    .ADDR_W(8), .DEPTH(DEPTH), .SEED(SEED),
    .SETUP_CYC(4), .STROBE_CYC(8), .CAPTURE_CYC(2), .DONE_CYC(1)
  ) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .fuseCs(fuseCs), .fuseLoad(fuseLoad), .fuseStrobe(fuseStrobe)
  );

  function automatic logic [31:0] expWord(input int a);
    logic [9:0] a10 = a[9:0];
    if (a >= DEPTH) return 32'h0;
    return {6'b0, a10, 6'b0, a10} ^ SEED;
  endfunction

  function automatic logic [31:0] startCmd(input int a);
    logic [9:0] a10 = a[9:0];
    return {6'b0, a10, 16'h0003};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0; regWdata = 32'h0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pinsWord(output logic [31:0] p);
    p = {29'b0, fuseCs, fuseLoad, fuseStrobe};
  endtask

  task automatic doRead(input int a, output logic [31:0] d);
    logic [31:0] s;
    wrReg(A_CTRL, startCmd(a));
    waitEdges(LATENCY - 1);
    rdReg(A_STATUS, s);
    chk("R3 flag not yet set", s, 32'h0);
    waitEdges(1);
    rdReg(A_STATUS, s);
    chk("R3 flag set at completion", s, 32'h1);
    rdReg(A_DOUT, d);
    wrReg(A_STATUS, 32'h1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rdReg(A_STATUS, v); chk("R1 status", v, 32'h0);
    rdReg(A_DOUT, v);   chk("R1 dout", v, 32'h0);
    rdReg(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
    pinsWord(v);        chk("R1 pins", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic testSingleBit();
    logic [31:0] v;
    wrReg(A_CTRL, 32'h0005_0001);
    rdReg(A_CTRL, v); chk("R2 enable-only busy", {31'b0, v[31]}, 32'h0);
    waitEdges(LATENCY + 3);
    rdReg(A_STATUS, v); chk("R2 enable-only flag", v, 32'h0);
    wrReg(A_CTRL, 32'h0005_0002);
    rdReg(A_CTRL, v); chk("R2 read-only busy", {31'b0, v[31]}, 32'h0);
    waitEdges(LATENCY + 3);
    rdReg(A_STATUS, v); chk("R2 read-only flag", v, 32'h0);
    wrReg(A_CTRL, 32'h0);
  endtask

  task automatic testTimingPins();
    logic [31:0] v;
    wrReg(A_CTRL, startCmd(5));
    rdReg(A_CTRL, v); chk("R3 busy after start", {31'b0, v[31]}, 32'h1);
    pinsWord(v); chk("R10 setup pins", v, 32'h6);
    waitEdges(3);
    pinsWord(v); chk("R10 last setup cycle pins", v, 32'h6);
    waitEdges(1);
    pinsWord(v); chk("R10 strobe phase pins", v, 32'h7);
    waitEdges(9);
    pinsWord(v); chk("R10 capture phase pins", v, 32'h7);
    waitEdges(1);
    rdReg(A_STATUS, v); chk("R3 flag low one edge early", v, 32'h0);
    rdReg(A_CTRL, v); chk("R3 busy one edge early", {31'b0, v[31]}, 32'h1);
    waitEdges(1);
    rdReg(A_STATUS, v); chk("R3 flag at edge 15", v, 32'h1);
    rdReg(A_CTRL, v); chk("R8 ctrl after idle", v, 32'h0005_0000);
    pinsWord(v); chk("R10 idle pins", v, 32'h0);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    rdReg(A_DOUT, v); chk("R4 word at 5", v, expWord(5));
  endtask

  task automatic testW1c();
    logic [31:0] v;
    wrReg(A_STATUS, 32'h0);
    rdReg(A_STATUS, v); chk("R6 write zero keeps flag", v, 32'h1);
    wrReg(A_STATUS, 32'hFFFF_FFFE);
    rdReg(A_STATUS, v); chk("R6 other bits ignored", v, 32'h1);
    chk("R6 irq follows flag", {31'b0, irq}, 32'h1);
    wrReg(A_STATUS, 32'h1);
    rdReg(A_STATUS, v); chk("R6 write one clears", v, 32'h0);
    chk("R6 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic testReads();
    logic [31:0] d;
    doRead(0, d);   chk("R4 word at 0", d, expWord(0));
    doRead(1, d);   chk("R4 word at 1", d, expWord(1));
    doRead(2, d);   chk("R4 word at 2", d, expWord(2));
    doRead(767, d); chk("R4 last word", d, expWord(767));
    doRead(768, d); chk("R5 first out-of-range", d, 32'h0);
    doRead(1023, d); chk("R5 top address", d, 32'h0);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    wrReg(A_CTRL, startCmd(100));
    waitEdges(4);
    wrReg(A_CTRL, startCmd(200));
    rdReg(A_CTRL, v); chk("R7 address kept", {22'b0, v[25:16]}, 32'd100);
    waitEdges(LATENCY - 6);
    rdReg(A_STATUS, v); chk("R7 no restart early flag", v, 32'h0);
    waitEdges(1);
    rdReg(A_STATUS, v); chk("R7 completion edge unchanged", v, 32'h1);
    rdReg(A_DOUT, v); chk("R7 result of first address", v, expWord(100));
    rdReg(A_CTRL, v); chk("R8 bits clear, address kept", v, 32'h0064_0000);
    wrReg(A_STATUS, 32'h1);
  endtask

  task automatic testHold();
    logic [31:0] v;
    logic [31:0] d;
    doRead(9, d);
    wrReg(A_DOUT, 32'hDEAD_BEEF);
    rdReg(A_DOUT, v); chk("R9 dout read-only", v, expWord(9));
    wrReg(A_CTRL, startCmd(10));
    waitEdges(10);
    rdReg(A_DOUT, v); chk("R9 dout holds mid-read", v, expWord(9));
    waitEdges(LATENCY - 10);
    rdReg(A_DOUT, v); chk("R9 dout updates after read", v, expWord(10));
    wrReg(A_STATUS, 32'h1);
    rdReg(A_DOUT, v); chk("R9 dout holds after clear", v, expWord(10));
  endtask

  task automatic testCollision();
    logic [31:0] v;
    wrReg(A_CTRL, startCmd(3));
    waitEdges(LATENCY - 1);
    wrReg(A_STATUS, 32'h1);
    rdReg(A_STATUS, v); chk("R11 set wins over clear", v, 32'h1);
    wrReg(A_STATUS, 32'h1);
    rdReg(A_STATUS, v); chk("R11 later clear works", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleBit();
    testTimingPins();
    testW1c();
    testReads();
    testBusyIgnore();
    testHold();
    testCollision();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule